// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block arbitrates eight interrupt request lines. It holds a request register, a mask register and an in-service register. Each input line is captured as edge or level triggered, selected per line. A rotating base pointer sets which line currently has the highest priority. Whenever an unmasked pending request ranks above every line still in service, the block raises its interrupt output and reports the winning line number.

A consumer takes an interrupt by pulsing an acknowledge with a line number. An end-of-service command releases in-service lines, either the highest-ranked one or a named one, and can optionally rotate priority. Automatic end-of-service, rotation on automatic end-of-service, a masked-level exclusion mode and a cascade-line exclusion for nested operation are chosen by static control inputs.

Top module: `prio_irq_resolver`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `int_out` is 0 and `win_line` is 0. Reset clears the request, mask, in-service and previous-level registers and sets the rotation base to 0, so line 0 ranks highest and line 7 ranks lowest.
- R2: On an edge-triggered line (`trig_lvl` bit 0), a 0-to-1 change seen between two clock edges sets the request bit. A falling input leaves that bit set. An input held high does not set the bit again after it has been cleared.
- R3: On a level-triggered line (`trig_lvl` bit 1), the request bit takes the input level on every clock edge. An acknowledge does not clear it.
- R4: The pending set is the request register ANDed with the inverse of the mask register. A mask write (`mask_we`) takes effect from the next clock edge.
- R5: Among pending lines, the winner is the first one found when scanning base, base+1, ... base+7, all modulo 8.
- R6: `int_out` is 1 only when the offset of the winning pending line is strictly less than the offset of the highest-ranked counted in-service line. `win_line` gives the winner when `int_out` is 1 and is 0 otherwise.
- R7: With `spec_mask_en` set, masked lines are left out of the in-service set when the service level is computed.
- R8: With `nested_master_en` set, in-service line 2 is left out when the service level is computed.
- R9: An acknowledge with `auto_eoi_en` clear sets the in-service bit of `ack_line`. Any acknowledge clears the request bit of that line if the line is edge triggered. A rising edge in the same cycle still sets the bit.
- R10: An acknowledge with `auto_eoi_en` set leaves the in-service register unchanged. If `rot_auto_en` is also set, the base becomes `ack_line`+1 modulo 8.
- R11: An end-of-service pulse with `eoi_specific` set clears in-service bit `eoi_line`. With `eoi_specific` clear, it clears the highest-ranked set in-service bit, scanning from the base over all bits. With `eoi_rotate` set, the base becomes the cleared line+1. A non-specific end-of-service with nothing in service changes nothing.
- R12: A `lowest_we` pulse makes `lowest_line` the lowest-priority line, so the base becomes `lowest_line`+1. When several base updates fall in the same cycle, the acknowledge rotation wins over the end-of-service rotation, which wins over the lowest-priority write. An in-service bit set by an acknowledge wins over a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 8 | Request inputs |
| trig_lvl | input | 8 | Per-line trigger mode, 1 = level, 0 = edge |
| mask_we | input | 1 | Load the mask register |
| mask_wdata | input | 8 | New mask value, 1 = masked |
| spec_mask_en | input | 1 | Exclude masked lines from the service level |
| nested_master_en | input | 1 | Exclude in-service line 2 from the service level |
| auto_eoi_en | input | 1 | Acknowledge does not set in-service |
| rot_auto_en | input | 1 | Rotate on automatic end-of-service |
| ack_valid | input | 1 | Acknowledge pulse |
| ack_line | input | 3 | Line being acknowledged |
| eoi_valid | input | 1 | End-of-service pulse |
| eoi_specific | input | 1 | Clear `eoi_line` rather than the highest-ranked bit |
| eoi_line | input | 3 | Line for a specific end-of-service |
| eoi_rotate | input | 1 | Rotate priority after the cleared line |
| lowest_we | input | 1 | Load a new lowest-priority line |
| lowest_line | input | 3 | Line to make lowest priority |
| int_out | output | 1 | Interrupt request to the consumer |
| win_line | output | 3 | Winning line number |

## Verification
The bench goes after the wrap of the priority scan past line 7. A design that scanned from a fixed index would report the wrong winner once the base moves. It holds an edge line high across an acknowledge: a design that kept re-arming would raise a phantom second interrupt, and one that cleared a level bit on acknowledge would drop a still-asserted request. It fires acknowledge, end-of-service and lowest-priority writes in the same cycle to expose a wrong precedence as a misplaced base. It also toggles the special-mask and nested exclusions over live in-service bits, where a design that ignored them would block an interrupt that should fire.

// File: rtl/prio_irq_resolver.sv
module prio_irq_resolver #(
  parameter int LINES        = 8,
  parameter int CASCADE_LINE = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LINES-1:0]         irq_lines,
  input  logic [LINES-1:0]         trig_lvl,
  input  logic                     mask_we,
  input  logic [LINES-1:0]         mask_wdata,
  input  logic                     spec_mask_en,
  input  logic                     nested_master_en,
  input  logic                     auto_eoi_en,
  input  logic                     rot_auto_en,
  input  logic                     ack_valid,
  input  logic [$clog2(LINES)-1:0] ack_line,
  input  logic                     eoi_valid,
  input  logic                     eoi_specific,
  input  logic [$clog2(LINES)-1:0] eoi_line,
  input  logic                     eoi_rotate,
  input  logic                     lowest_we,
  input  logic [$clog2(LINES)-1:0] lowest_line,
  output logic                     int_out,
  output logic [$clog2(LINES)-1:0] win_line
);
  localparam int IDXW = $clog2(LINES);
  localparam logic [IDXW:0] NONE = (IDXW+1)'(LINES);
  localparam logic [LINES-1:0] CASC_BIT = LINES'(1) << CASCADE_LINE;
  localparam logic [IDXW-1:0] ONE = IDXW'(1);

  logic [LINES-1:0] irr, imr, isr, last;
  logic [IDXW-1:0]  base;
  logic             up;

  function automatic logic [IDXW:0] scan_off(input logic [LINES-1:0] m,
                                             input logic [IDXW-1:0] b);
    logic [IDXW-1:0] idx;
    scan_off = NONE;
    for (int k = LINES-1; k >= 0; k--) begin
      idx = b + IDXW'(k);
      if (m[idx]) scan_off = (IDXW+1)'(k);
    end
  endfunction

  logic [LINES-1:0] pend, svc;
  logic [IDXW:0]    pend_off, svc_off, isr_off;
  logic             fire;

  assign pend     = irr & ~imr;
  assign svc      = isr & (spec_mask_en ? ~imr : '1) & (nested_master_en ? ~CASC_BIT : '1);
  assign pend_off = scan_off(pend, base);
  assign svc_off  = scan_off(svc, base);
  assign fire     = pend_off < svc_off;
  assign int_out  = fire;
  assign win_line = fire ? pend_off[IDXW-1:0] + base : '0;

  logic [LINES-1:0] ack_clr, ack_set, edge_set, eoi_clr, irr_nx, isr_nx;
  logic [IDXW-1:0]  eoi_tgt, base_nx;
  logic             eoi_hit;

  assign isr_off  = scan_off(isr, base);
  assign eoi_tgt  = eoi_specific ? eoi_line : isr_off[IDXW-1:0] + base;
  assign eoi_hit  = eoi_valid && (eoi_specific || isr_off != NONE);
  assign eoi_clr  = eoi_hit ? (LINES'(1) << eoi_tgt) : '0;
  assign ack_clr  = ack_valid ? (LINES'(1) << ack_line) : '0;
  assign ack_set  = (ack_valid && !auto_eoi_en) ? ack_clr : '0;
  assign edge_set = irq_lines & ~last;
  assign irr_nx   = (trig_lvl & irq_lines) | (~trig_lvl & ((irr & ~ack_clr) | edge_set));
  assign isr_nx   = (isr & ~eoi_clr) | ack_set;

  always_comb begin
    base_nx = base;
    if (lowest_we)                                      base_nx = lowest_line + ONE;
    if (eoi_hit && eoi_rotate)                          base_nx = eoi_tgt + ONE;
    if (ack_valid && auto_eoi_en && rot_auto_en)        base_nx = ack_line + ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr  <= '0;
      imr  <= '0;
      isr  <= '0;
      last <= '0;
      base <= '0;
      up   <= 1'b0;
    end else begin
      irr  <= irr_nx;
      isr  <= isr_nx;
      last <= irq_lines;
      base <= base_nx;
      if (mask_we) imr <= mask_wdata;
      up   <= 1'b1;
    end
  end

  // R2
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up |-> ((($past(irr) & ~$past(trig_lvl) & ~$past(ack_clr)) & ~irr) == '0));

  // R3
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up |-> ((irr & $past(trig_lvl)) == ($past(irq_lines) & $past(trig_lvl))));

  // R6
  fire_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> pend[win_line]);

  // R9
  ack_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up && $past(ack_valid && !auto_eoi_en)) |-> isr[$past(ack_line)]);

  // R10
  auto_no_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up && $past(ack_valid && auto_eoi_en)) |-> !(isr[$past(ack_line)] && !$past(isr[ack_line])));

  // R10
  auto_rot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up && $past(ack_valid && auto_eoi_en && rot_auto_en)) |-> (base == $past(ack_line) + ONE));
endmodule

// File: tb/sim_prio_irq_resolver.sv
module sim_prio_irq_resolver;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0, rst_n = 0;
  logic [7:0] irq_lines = 0, trig_lvl = 0, mask_wdata = 0;
  logic       mask_we = 0, spec_mask_en = 0, nested_master_en = 0, auto_eoi_en = 0, rot_auto_en = 0;
  logic       ack_valid = 0, eoi_valid = 0, eoi_specific = 0, eoi_rotate = 0, lowest_we = 0;
  logic [2:0] ack_line = 0, eoi_line = 0, lowest_line = 0;
  logic       int_out;
  logic [2:0] win_line;

  int checks = 0, failures = 0, cyc = 0;
  string cur_req = "R1";

  prio_irq_resolver u0 (.clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .trig_lvl(trig_lvl),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .spec_mask_en(spec_mask_en),
    .nested_master_en(nested_master_en), .auto_eoi_en(auto_eoi_en), .rot_auto_en(rot_auto_en),
    .ack_valid(ack_valid), .ack_line(ack_line), .eoi_valid(eoi_valid), .eoi_specific(eoi_specific),
    .eoi_line(eoi_line), .eoi_rotate(eoi_rotate), .lowest_we(lowest_we), .lowest_line(lowest_line),
    .int_out(int_out), .win_line(win_line));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference state
  bit [7:0] m_irr, m_isr, m_imr, m_last;
  int m_base;

  function automatic int first_from(bit [7:0] m, int b);
    for (int k = 0; k < 8; k++) if (m[(k + b) % 8]) return k;
    return 8;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_irr = 0; m_isr = 0; m_imr = 0; m_last = 0; m_base = 0;
    end else begin
      int nb, tgt, off;
      bit [7:0] ni;
      nb = m_base;
      ni = m_isr;
      for (int i = 0; i < 8; i++) begin
        if (trig_lvl[i]) m_irr[i] = irq_lines[i];
        else begin
          if (ack_valid && ack_line == i) m_irr[i] = 0;
          if (irq_lines[i] && !m_last[i]) m_irr[i] = 1;
        end
      end
      m_last = irq_lines;
      if (lowest_we) nb = (lowest_line + 1) % 8;
      if (eoi_valid) begin
        tgt = -1;
        if (eoi_specific) tgt = eoi_line;
        else begin
          off = first_from(m_isr, m_base);
          if (off < 8) tgt = (off + m_base) % 8;
        end
        if (tgt >= 0) begin
          ni[tgt] = 0;
          if (eoi_rotate) nb = (tgt + 1) % 8;
        end
      end
      if (ack_valid) begin
        if (!auto_eoi_en) ni[ack_line] = 1;
        else if (rot_auto_en) nb = (ack_line + 1) % 8;
      end
      m_isr = ni;
      m_base = nb;
      if (mask_we) m_imr = mask_wdata;
    end
  end

  task automatic compare();
    bit [7:0] pend, svc;
    int po, so, e_line;
    bit e_int;
    pend = m_irr & ~m_imr;
    svc  = m_isr & (spec_mask_en ? ~m_imr : 8'hFF) & (nested_master_en ? 8'hFB : 8'hFF);
    po = first_from(pend, m_base);
    so = first_from(svc, m_base);
    e_int = po < so;
    e_line = e_int ? (po + m_base) % 8 : 0;
    checks++;
    if (int_out !== e_int || win_line !== 3'(e_line)) begin
      failures++;
      $display("FAIL %s cycle %0d: int_out=%0b win_line=%0d expected int_out=%0b win_line=%0d",
               cur_req, cyc, int_out, win_line, e_int, e_line);
    end
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
    end
  endtask

  task automatic clear_pulses();
    ack_valid = 0; eoi_valid = 0; lowest_we = 0; mask_we = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; irq_lines = 0; trig_lvl = 0; spec_mask_en = 0; nested_master_en = 0;
    auto_eoi_en = 0; rot_auto_en = 0; eoi_specific = 0; eoi_rotate = 0; clear_pulses();
    tick(3);
    rst_n = 1;
    tick(1);
  endtask

  task automatic ack(int l);
    ack_valid = 1; ack_line = 3'(l); tick(); ack_valid = 0; tick();
  endtask

  task automatic eoi(bit spec, int l, bit rot);
    eoi_valid = 1; eoi_specific = spec; eoi_line = 3'(l); eoi_rotate = rot;
    tick(); eoi_valid = 0; eoi_rotate = 0; tick();
  endtask

  initial begin
    // R1 reset state
    cur_req = "R1";
    do_reset();
    irq_lines = 8'h81; tick(2);

    // R2 edge capture and hold
    do_reset(); cur_req = "R2";
    irq_lines = 8'h08; tick(2);
    irq_lines = 8'h00; tick(2);
    ack(3); tick(2);
    irq_lines = 8'h08; tick(2);
    eoi(0, 0, 0);
    irq_lines = 8'h08; tick(3);
    irq_lines = 8'h00; tick(); irq_lines = 8'h08; tick(2);

    // R3 level capture, ack does not clear
    do_reset(); cur_req = "R3";
    trig_lvl = 8'h20; irq_lines = 8'h20; tick(2);
    ack(5); eoi(0, 0, 0); tick();
    irq_lines = 8'h00; tick(2);

    // R4 masking
    do_reset(); cur_req = "R4";
    irq_lines = 8'h10; tick();
    mask_we = 1; mask_wdata = 8'h10; tick(); mask_we = 0; tick(2);
    mask_we = 1; mask_wdata = 8'h00; tick(); mask_we = 0; tick(2);

    // R5 rotation wrap and R12 lowest write
    do_reset(); cur_req = "R5";
    irq_lines = 8'h42; tick(2);
    cur_req = "R12";
    lowest_we = 1; lowest_line = 3; tick(); lowest_we = 0; tick(2);
    lowest_we = 1; lowest_line = 6; tick(); lowest_we = 0; tick(2);

    // R6 nesting against in-service
    do_reset(); cur_req = "R6";
    irq_lines = 8'h04; tick(); ack(2);
    irq_lines = 8'h24; tick(2);
    irq_lines = 8'h25; tick(2);

    // R7 special mask
    do_reset(); cur_req = "R7";
    irq_lines = 8'h02; tick(); ack(1);
    irq_lines = 8'h42; tick(2);
    mask_we = 1; mask_wdata = 8'h02; tick(); mask_we = 0; tick();
    spec_mask_en = 1; tick(2);

    // R8 nested master
    do_reset(); cur_req = "R8";
    irq_lines = 8'h04; tick(); ack(2);
    irq_lines = 8'h00; tick(); irq_lines = 8'h04; tick(2);
    nested_master_en = 1; tick(2);

    // R9 ack with edge rising in the same cycle
    do_reset(); cur_req = "R9";
    irq_lines = 8'h01; tick();
    irq_lines = 8'h00; tick();
    ack_valid = 1; ack_line = 0; irq_lines = 8'h01; tick(); ack_valid = 0; tick(2);

    // R10 auto end-of-service with rotation
    do_reset(); cur_req = "R10";
    auto_eoi_en = 1; rot_auto_en = 1;
    irq_lines = 8'h09; tick(2);
    ack(0); tick(); ack(3); tick(2);

    // R11 end-of-service forms
    do_reset(); cur_req = "R11";
    irq_lines = 8'h13; tick(); ack(0); ack(1);
    irq_lines = 8'h00; tick(); irq_lines = 8'h10; tick();
    eoi(0, 0, 0); tick(); eoi(1, 0, 1); tick(2);
    eoi(0, 0, 1); eoi(0, 0, 1); tick(2);

    // R12 same-cycle precedence
    do_reset(); cur_req = "R12";
    auto_eoi_en = 1; rot_auto_en = 1;
    irq_lines = 8'hFF; tick();
    ack_valid = 1; ack_line = 4; eoi_valid = 1; eoi_specific = 1; eoi_line = 1; eoi_rotate = 1;
    lowest_we = 1; lowest_line = 6; tick(); clear_pulses(); tick(2);
    auto_eoi_en = 0;
    ack_valid = 1; ack_line = 2; eoi_valid = 1; eoi_specific = 1; eoi_line = 2; eoi_rotate = 0;
    tick(); clear_pulses(); tick(2);

    // R5 broad randomized traffic
    do_reset(); cur_req = "R5";
    for (int n = 0; n < 4000; n++) begin
      clear_pulses();
      if ($urandom_range(3) == 0) irq_lines = irq_lines ^ 8'($urandom_range(255));
      if ($urandom_range(40) == 0) trig_lvl = 8'($urandom_range(255));
      if ($urandom_range(30) == 0) begin mask_we = 1; mask_wdata = 8'($urandom_range(255)) & 8'($urandom_range(255)); end
      if ($urandom_range(60) == 0) spec_mask_en = ~spec_mask_en;
      if ($urandom_range(60) == 0) nested_master_en = ~nested_master_en;
      if ($urandom_range(80) == 0) auto_eoi_en = ~auto_eoi_en;
      if ($urandom_range(80) == 0) rot_auto_en = ~rot_auto_en;
      if ($urandom_range(5) == 0) begin ack_valid = 1; ack_line = int_out ? win_line : 3'($urandom_range(7)); end
      if ($urandom_range(6) == 0) begin
        eoi_valid = 1; eoi_specific = 1'($urandom_range(1));
        eoi_line = 3'($urandom_range(7)); eoi_rotate = 1'($urandom_range(1));
      end
      if ($urandom_range(25) == 0) begin lowest_we = 1; lowest_line = 3'($urandom_range(7)); end
      tick();
    end
    clear_pulses(); tick(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    failures++;
    $display("FAIL watchdog expired at cycle %0d, expected completion", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule